// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the first six bytes of every received frame, which carry the destination address, and decides whether the frame is kept or dropped. It compares the address with the station's own address one byte at a time. It also runs a CRC-32 over the same bytes to pick one bit of a 64-entry multicast hash table. A 2-bit filter mode then selects one of four acceptance policies.

When the decision is made, the block reports four classification flags for the receive status word: own-address match, multicast hash hit, broadcast and multicast. It also keeps an interrupt-status bit that takes the hash table output while receive DMA is switched on.

Bytes arrive on a valid-qualified byte stream. A start marker flags the first byte of each frame. Everything after the sixth byte of a frame passes the block without effect.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is asserted and after its release, before any frame, `dec_valid`, `dec_accept`, all four flags and `hash_stat` are 0.
- R2: A byte is taken only when `in_valid` is 1. `in_sof` with `in_valid` starts a new address at byte 0 and abandons any partial one. Address byte k (0 = first received) is compared with `station_addr[8k+7:8k]`. Bytes after the sixth, and bytes with `in_sof` low while no address is open, are ignored.
- R3: `dec_valid` is a one-cycle pulse in the cycle after the clock edge that takes the sixth address byte. `dec_accept` and the flags change only together with that pulse and hold their value until the next one.
- R4: `flag_phys` is 1 when all six bytes equal the station address. `flag_bcast` is 1 when all 48 bits are 1. `flag_mcast` is bit 0 of the first byte, so a broadcast is also multicast.
- R5: The hash index is bits [31:26] of a CRC register that starts at all ones and absorbs each address byte LSB first using the reflected polynomial 0xEDB88320, with no final complement. The hit is `hash_table[index]`, and `flag_hash` is hit AND multicast.
- R6: With `filt_mode` 00, a frame is accepted only on an own-address match.
- R7: With `filt_mode` 01, a frame is accepted on an own-address match, on broadcast, or when it is multicast and the hash hits.
- R8: With `filt_mode` 10, a frame is accepted on an own-address match, on broadcast, or when it is multicast.
- R9: With `filt_mode` 11, every frame is accepted.
- R10: `filt_mode` and `dma_rx_on` are sampled in the cycle that carries the sixth byte. When `dma_rx_on` is 1, `hash_stat` loads the raw hash hit, whatever the multicast bit is. Otherwise `hash_stat` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is valid this cycle |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_byte | input | 8 | Received byte |
| filt_mode | input | 2 | Acceptance policy: 00 own, 01 hash, 10 all multicast, 11 all |
| station_addr | input | 48 | Own address, first received byte in bits [7:0] |
| hash_table | input | 64 | Multicast hash table, one bit per index |
| dma_rx_on | input | 1 | Receive DMA enabled; gates the hash status bit |
| dec_valid | output | 1 | One-cycle pulse: decision and flags updated |
| dec_accept | output | 1 | Frame accepted |
| flag_phys | output | 1 | Own-address match |
| flag_hash | output | 1 | Multicast frame hit the hash table |
| flag_bcast | output | 1 | Broadcast address |
| flag_mcast | output | 1 | Multicast address |
| hash_stat | output | 1 | Hash output latched while DMA is on |

## Verification
Every result of this block is due in the cycle after the clock edge that takes the sixth address byte. The bench drives bytes on the falling edge. It waits for the rising edge that takes the sixth byte and reads all outputs 1 ns later. In each following cycle, whether it carries payload bytes or is idle, it checks that `dec_valid` is back at 0 and that the decision and flags still hold, since they change only with the next decision. Random gaps between address bytes shift the due cycle. The bench follows the shift by counting only the edges that take a valid byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        FM_OWN     = 2'b00,
        FM_HASH    = 2'b01,
        FM_ALLMC   = 2'b10,
        FM_PROMISC = 2'b11
    } fmode_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef struct packed {
        logic valid;
        logic accept;
        logic phys;
        logic hash;
        logic bcast;
        logic mcast;
        logic hstat;
    } dec_s;

endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte
    import rxf_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);
    logic [31:0] c;
    logic        fb;

    // bit-serial reflected update, LSB of the byte first
    always_comb begin
        c  = crc_in;
        fb = 1'b0;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data[i];
            c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
        end
        crc_out = c;
    end
endmodule

// File: rtl/rxf_addr_track.sv
module rxf_addr_track #(
    parameter int N_BYTES = 6,
    localparam int CW     = $clog2(N_BYTES + 1),
    localparam int AW     = 8 * N_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic [7:0]    in_byte,
    input  logic [AW-1:0] station_addr,
    output logic          done,
    output logic          out_phys,
    output logic          out_bcast,
    output logic          out_mcast,
    output logic [31:0]   out_crc
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phys;
        logic          ones;
        logic          mc;
        logic [31:0]   crc;
    } trk_s;

    trk_s          st_q, st_d;
    logic          take;
    logic [CW-1:0] pos;
    logic          base_phys, base_ones, base_mc;
    logic [31:0]   base_crc, crc_nx;
    logic          byte_eq;

    assign base_crc = in_sof ? 32'hFFFF_FFFF : st_q.crc;

    rxf_crc_byte u_crc (
        .crc_in  (base_crc),
        .data    (in_byte),
        .crc_out (crc_nx)
    );

    always_comb begin
        take      = in_valid && (in_sof || (st_q.cnt < CW'(N_BYTES)));
        pos       = in_sof ? '0 : st_q.cnt;
        base_phys = in_sof ? 1'b1 : st_q.phys;
        base_ones = in_sof ? 1'b1 : st_q.ones;
        base_mc   = in_sof ? in_byte[0] : st_q.mc;
        byte_eq   = (in_byte == station_addr[8*int'(pos) +: 8]);
        st_d      = st_q;
        if (take) begin
            st_d.cnt  = pos + CW'(1);
            st_d.phys = base_phys & byte_eq;
            st_d.ones = base_ones & (&in_byte);
            st_d.mc   = base_mc;
            st_d.crc  = crc_nx;
        end
        done      = take && (pos == CW'(N_BYTES - 1));
        out_phys  = st_d.phys;
        out_bcast = st_d.ones;
        out_mcast = st_d.mc;
        out_crc   = st_d.crc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= CW'(N_BYTES);
            st_q.phys <= 1'b0;
            st_q.ones <= 1'b0;
            st_q.mc   <= 1'b0;
            st_q.crc  <= 32'hFFFF_FFFF;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: the byte position never runs past the address length
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(N_BYTES));

    // R2: a start marker always reopens the address at its second position
    p_sof_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (st_q.cnt == CW'(1)));
endmodule

// File: rtl/rxf_mode_sel.sv
module rxf_mode_sel
    import rxf_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       phys,
    input  logic       bcast,
    input  logic       mcast,
    input  logic       hit,
    output logic       accept
);
    always_comb begin
        unique case (fmode_e'(mode))
            FM_OWN:     accept = phys;
            FM_HASH:    accept = phys | bcast | (mcast & hit);
            FM_ALLMC:   accept = phys | bcast | mcast;
            FM_PROMISC: accept = 1'b1;
            default:    accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int AW        = 8 * ADDR_BYTES,
    localparam int TBL       = 1 << HASH_BITS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_sof,
    input  logic [7:0]     in_byte,
    input  logic [1:0]     filt_mode,
    input  logic [AW-1:0]  station_addr,
    input  logic [TBL-1:0] hash_table,
    input  logic           dma_rx_on,
    output logic           dec_valid,
    output logic           dec_accept,
    output logic           flag_phys,
    output logic           flag_hash,
    output logic           flag_bcast,
    output logic           flag_mcast,
    output logic           hash_stat
);
    dec_s                 dec_q, dec_d;
    logic                 done;
    logic                 cur_phys, cur_bcast, cur_mcast;
    logic [31:0]          cur_crc;
    logic [HASH_BITS-1:0] hidx;
    logic                 hit;
    logic                 acc;

    rxf_addr_track #(.N_BYTES(ADDR_BYTES)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_byte      (in_byte),
        .station_addr (station_addr),
        .done         (done),
        .out_phys     (cur_phys),
        .out_bcast    (cur_bcast),
        .out_mcast    (cur_mcast),
        .out_crc      (cur_crc)
    );

    assign hidx = cur_crc[31 -: HASH_BITS];
    assign hit  = hash_table[hidx];

    rxf_mode_sel u_mode (
        .mode   (filt_mode),
        .phys   (cur_phys),
        .bcast  (cur_bcast),
        .mcast  (cur_mcast),
        .hit    (hit),
        .accept (acc)
    );

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = done;
        if (done) begin
            dec_d.accept = acc;
            dec_d.phys   = cur_phys;
            dec_d.hash   = hit & cur_mcast;
            dec_d.bcast  = cur_bcast;
            dec_d.mcast  = cur_mcast;
            if (dma_rx_on) begin
                dec_d.hstat = hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
    assign flag_phys  = dec_q.phys;
    assign flag_hash  = dec_q.hash;
    assign flag_bcast = dec_q.bcast;
    assign flag_mcast = dec_q.mcast;
    assign hash_stat  = dec_q.hstat;

    // R3: the decision strobe never lasts two cycles
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R3: outside a strobe the reported decision stays put
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> ($stable(dec_accept) && $stable(flag_phys) && $stable(flag_mcast)));

    // R4: broadcast always reports as multicast as well
    p_bcast_mcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_bcast |-> flag_mcast);

    // R5: a hash hit is only flagged for multicast frames
    p_hash_mcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hash |-> flag_mcast);

    // R6: own-address mode follows the address match exactly
    p_mode_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(filt_mode) == 2'b00) |-> (dec_accept == flag_phys));

    // R9: promiscuous mode accepts everything
    p_promisc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(filt_mode) == 2'b11) |-> dec_accept);

    // R10: hash status is frozen while receive DMA is off
    p_hstat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dma_rx_on) |-> $stable(hash_stat));
endmodule

// File: tb/rx_dest_filter_bench.sv
module rx_dest_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [1:0]  filt_mode = 2'b00;
    logic [47:0] station_addr = 48'h44_9E_21_3C_5A_02;
    logic [63:0] hash_table = 64'h0;
    logic        dma_rx_on = 1'b0;
    logic        dec_valid, dec_accept, flag_phys, flag_hash, flag_bcast, flag_mcast, hash_stat;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic exp_acc = 0, exp_phys = 0, exp_hash = 0, exp_bc = 0, exp_mc = 0, exp_hs = 0;

    always #5 clk = ~clk;

    rx_dest_filter u_rx_dest_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_byte      (in_byte),
        .filt_mode    (filt_mode),
        .station_addr (station_addr),
        .hash_table   (hash_table),
        .dma_rx_on    (dma_rx_on),
        .dec_valid    (dec_valid),
        .dec_accept   (dec_accept),
        .flag_phys    (flag_phys),
        .flag_hash    (flag_hash),
        .flag_bcast   (flag_bcast),
        .flag_mcast   (flag_mcast),
        .hash_stat    (hash_stat)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 8; i++) begin
                if (c[0] ^ a[8*k+i]) c = {1'b0, c[31:1]} ^ 32'hEDB88320;
                else                 c = {1'b0, c[31:1]};
            end
        end
        return c[31:26];
    endfunction

    task automatic drive_byte(input logic sof, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = sof;
        in_byte  = b;
    endtask

    task automatic drive_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_byte  = 8'($urandom);
    endtask

    task automatic check_hold(input string why);
        @(posedge clk);
        #1;
        chk("R2", {"no strobe ", why}, 32'(dec_valid), 32'd0);
        chk("R3", {"decision held ", why}, 32'({dec_accept, flag_phys, flag_hash, flag_bcast, flag_mcast}),
            32'({exp_acc, exp_phys, exp_hash, exp_bc, exp_mc}));
    endtask

    task automatic run_frame(input logic [47:0] a, input logic [1:0] m, input logic dma, input bit gaps);
        logic hit;
        int   npay;
        hit      = hash_table[ref_index(a)];
        exp_phys = (a == station_addr);
        exp_bc   = (a == 48'hFFFF_FFFF_FFFF);
        exp_mc   = a[0];
        exp_hash = hit & a[0];
        case (m)
            2'b00:   exp_acc = exp_phys;
            2'b01:   exp_acc = exp_phys | exp_bc | (exp_mc & hit);
            2'b10:   exp_acc = exp_phys | exp_bc | exp_mc;
            default: exp_acc = 1'b1;
        endcase
        if (dma) exp_hs = hit;
        for (int k = 0; k < 6; k++) begin
            if (gaps && k > 0 && ($urandom % 3 == 0)) drive_idle();
            drive_byte(k == 0, a[8*k +: 8]);
            if (k == 5) begin
                filt_mode = m;
                dma_rx_on = dma;
            end
        end
        @(posedge clk);
        #1;
        chk("R3", "strobe after sixth byte", 32'(dec_valid), 32'd1);
        chk("R4", "phys/bcast/mcast", 32'({flag_phys, flag_bcast, flag_mcast}), 32'({exp_phys, exp_bc, exp_mc}));
        chk("R5", "hash flag", 32'(flag_hash), 32'(exp_hash));
        case (m)
            2'b00:   chk("R6", "accept mode 00", 32'(dec_accept), 32'(exp_acc));
            2'b01:   chk("R7", "accept mode 01", 32'(dec_accept), 32'(exp_acc));
            2'b10:   chk("R8", "accept mode 10", 32'(dec_accept), 32'(exp_acc));
            default: chk("R9", "accept mode 11", 32'(dec_accept), 32'(exp_acc));
        endcase
        chk("R10", "hash status", 32'(hash_stat), 32'(exp_hs));
        npay = $urandom % 3;
        for (int p = 0; p < npay; p++) begin
            drive_byte(1'b0, 8'($urandom));
            filt_mode = 2'($urandom);
            check_hold("payload");
        end
        drive_idle();
        check_hold("idle");
    endtask

    function automatic logic [47:0] pick_addr(input int kind);
        logic [47:0] a = {16'($urandom), $urandom};
        case (kind)
            0: return station_addr;
            1: return 48'hFFFF_FFFF_FFFF;
            2: return {a[47:1], 1'b1};
            default: return {a[47:1], 1'b0};
        endcase
    endfunction

    initial begin
        logic [47:0] mca;
        logic [5:0]  mi;
        void'($urandom(32'd1234));
        hash_table = {$urandom, $urandom};
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "outputs in reset", 32'({dec_valid, dec_accept, flag_phys, flag_hash, flag_bcast, flag_mcast, hash_stat}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "outputs after reset", 32'({dec_valid, dec_accept, flag_phys, flag_hash, flag_bcast, flag_mcast, hash_stat}), 32'd0);

        // stray bytes without a start marker are ignored (R2)
        drive_byte(1'b0, station_addr[7:0]);
        check_hold("stray byte");

        // directed: every kind of address in every mode
        for (int m = 0; m < 4; m++)
            for (int kind = 0; kind < 4; kind++)
                run_frame(pick_addr(kind), 2'(m), 1'b1, 1'b0);

        // directed hash hit and miss in mode 01 (R7, R5)
        mca = 48'h0000_1234_5601 | {16'($urandom), 32'h0};
        mi  = ref_index(mca);
        hash_table[mi] = 1'b1;
        run_frame(mca, 2'b01, 1'b1, 1'b0);
        hash_table[mi] = 1'b0;
        run_frame(mca, 2'b01, 1'b1, 1'b0);
        hash_table[mi] = 1'b1;
        run_frame(mca, 2'b01, 1'b0, 1'b0);

        // a start marker mid-address abandons the partial one (R2)
        drive_byte(1'b1, station_addr[7:0]);
        drive_byte(1'b0, station_addr[15:8]);
        drive_byte(1'b0, station_addr[23:16]);
        run_frame(48'hFFFF_FFFF_FFFF, 2'b00, 1'b1, 1'b0);

        // own address differing only in its last byte (R4)
        run_frame(station_addr ^ 48'h0100_0000_0000, 2'b00, 1'b1, 1'b0);

        // random frames with random gaps
        for (int n = 0; n < 300; n++) begin
            if (n % 50 == 0) hash_table = {$urandom, $urandom};
            run_frame(pick_addr(int'($urandom % 4)), 2'($urandom), 1'($urandom), 1'b1);
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule